// File: doc/BRIEF.md
# Event Interrupt Register Set

This block holds the interrupt state for a group of completion events behind a simple word-addressed register bus. Each event has a raw pending flag and an enable bit. A hardware pulse on an event input raises that event's raw flag. Software can raise flags for diagnostics, drop them explicitly, or poll them. The enabled pending flags are ORed onto a single interrupt line.

Software usually services the line by reading the index register. That read returns the number of the most urgent enabled pending event and retires that event's raw flag, so one bus access both identifies and acknowledges the source. The event count is a parameter, and event 0 is the completion event. Reads are combinational: the read data is valid in the same cycle as the read strobe, and any side effect of the read takes hold at the next clock edge.

Top module: `irq_event_regs`

## Requirements
- R1: After reset the raw flags and the enable bits are all 0, the interrupt line is low, and the index register reads 0.
- R2: The enable register (word address 0) is read/write. Bit k enables event k. Bits at and above NUM_EVT read as 0.
- R3: The masked status register (address 2) reads as raw AND enable, and the interrupt line is high exactly when that value is nonzero.
- R4: A one-cycle pulse on bit k of `evt_i` sets raw flag k at the next clock edge and leaves the other flags unchanged.
- R5: Writing 1 to bit k of the set register (address 3) sets raw flag k. Writing 0 to a bit of it changes nothing.
- R6: Writing 1 to bit k of the clear register (address 4) clears raw flag k, even when enable bit k is 0. Writing 0 to a bit of it changes nothing.
- R7: The set and clear registers read as 0. Writes to the raw status (address 1), masked status (address 2) and index (address 5) addresses change no state.
- R8: The index register (address 5) reads as k+1, where k is the lowest-numbered event that is both raw-pending and enabled. It reads 0 when no such event exists.
- R9: A read of the index register clears only the raw flag of the event it reports. When it reports 0, it clears nothing, and pending flags that are not enabled are never cleared by it.
- R10: When a hardware pulse and a clear (a clear-register write or an index read) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Word address of the access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read strobe; the index read side effect requires it |
| rd_data_o | output | DATA_W | Read data, valid with rd_en_i, 0 otherwise |
| evt_i | input | NUM_EVT | Hardware event pulses, one per event |
| irq_o | output | 1 | Interrupt line, OR of enabled pending flags |

## Verification
Two things can land on one flag in the same cycle: a hardware event pulse and a clear. The clear may come from a clear-register write or from the retirement done by an index read. The bench provokes both cases. It drives the event pulse in the same cycle as the bus access that targets the same bit. It then reads the raw status, which must show the flag still set, and for the index read it also checks that the returned index is the pre-edge value. A sweep over every combination of raw and enable values in a four-event build covers the priority choice and the single-bit retirement.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

    // Register word addresses (zero-extended to the bus address width)
    typedef enum logic [2:0] {
        RA_ENABLE = 3'd0,
        RA_RAW    = 3'd1,
        RA_MASKED = 3'd2,
        RA_SET    = 3'd3,
        RA_CLEAR  = 3'd4,
        RA_INDEX  = 3'd5
    } reg_addr_e;

    // Per-register strobes produced by the decoder
    typedef struct packed {
        logic enable_we;
        logic set_we;
        logic clear_we;
        logic index_rd;
    } wr_strb_t;

    typedef struct packed {
        logic enable;
        logic raw;
        logic masked;
        logic index;
    } rd_sel_t;

endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
    import irq_regs_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    output wr_strb_t          strb_o,
    output rd_sel_t           rsel_o
);

    function automatic logic hit(input logic [ADDR_W-1:0] a, input reg_addr_e r);
        return a == ADDR_W'(r);
    endfunction

    always_comb begin
        strb_o.enable_we = wr_en_i && hit(addr_i, RA_ENABLE);
        strb_o.set_we    = wr_en_i && hit(addr_i, RA_SET);
        strb_o.clear_we  = wr_en_i && hit(addr_i, RA_CLEAR);
        strb_o.index_rd  = rd_en_i && hit(addr_i, RA_INDEX);

        rsel_o.enable    = rd_en_i && hit(addr_i, RA_ENABLE);
        rsel_o.raw       = rd_en_i && hit(addr_i, RA_RAW);
        rsel_o.masked    = rd_en_i && hit(addr_i, RA_MASKED);
        rsel_o.index     = rd_en_i && hit(addr_i, RA_INDEX);
    end

endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned NUM_EVT = 4,
    localparam int unsigned IDX_W  = $clog2(NUM_EVT + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] pend_i,
    output logic [NUM_EVT-1:0] grant_o,
    output logic [IDX_W-1:0]   index_o
);

    // below[i] is high when any lower-numbered event is pending
    logic [NUM_EVT-1:0] below;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < NUM_EVT; g++) begin : g_chain
            assign below[g] = below[g-1] | pend_i[g-1];
        end
        for (g = 0; g < NUM_EVT; g++) begin : g_grant
            assign grant_o[g] = pend_i[g] & ~below[g];
        end
    endgenerate

    always_comb begin
        index_o = '0;
        for (int i = NUM_EVT - 1; i >= 0; i--) begin
            if (grant_o[i]) index_o = IDX_W'(i + 1);
        end
    end

    // R8: at most one event is ever selected
    a_r8_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R8: nothing pending means an index of zero
    a_r8_idle_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> (index_o == '0));

endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  wr_strb_t           strb_i,
    input  logic [NUM_EVT-1:0] wdata_i,
    input  logic [NUM_EVT-1:0] hw_evt_i,
    input  logic [NUM_EVT-1:0] idx_clr_i,
    output logic [NUM_EVT-1:0] raw_o,
    output logic [NUM_EVT-1:0] enable_o
);

    typedef struct packed {
        logic [NUM_EVT-1:0] raw;
        logic [NUM_EVT-1:0] enable;
    } flag_state_t;

    flag_state_t        st_d, st_q;
    logic [NUM_EVT-1:0] set_v, clr_v;

    always_comb begin
        set_v = hw_evt_i | (strb_i.set_we ? wdata_i : '0);
        clr_v = idx_clr_i | (strb_i.clear_we ? wdata_i : '0);
        st_d        = st_q;
        st_d.raw    = (st_q.raw & ~clr_v) | set_v;
        if (strb_i.enable_we) st_d.enable = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_o    = st_q.raw;
    assign enable_o = st_q.enable;

    // R4 / R10: every hardware pulse leaves its flag set
    a_r4_hw_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt_i != '0) |=> ((raw_o & $past(hw_evt_i)) == $past(hw_evt_i)));

    // R2: enable register takes the written value
    a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        strb_i.enable_we |=> (enable_o == $past(wdata_i)));

    // R6: clear-register write drops flags not raised in the same cycle
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_i.clear_we && hw_evt_i == '0) |=> ((raw_o & $past(wdata_i)) == '0));

    // R9: an index read retires the reported flag
    a_r9_index_retires: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_clr_i != '0) && ((hw_evt_i & idx_clr_i) == '0) && !strb_i.set_we)
        |=> ((raw_o & $past(idx_clr_i)) == '0));

    // R7: enable only changes on its own write strobe
    a_r7_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_i.enable_we |=> $stable(enable_o));

endmodule

// File: rtl/irq_event_regs.sv
module irq_event_regs
    import irq_regs_pkg::*;
#(
    parameter int unsigned NUM_EVT = 4,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    input  logic               rd_en_i,
    output logic [DATA_W-1:0]  rd_data_o,
    input  logic [NUM_EVT-1:0] evt_i,
    output logic               irq_o
);

    localparam int unsigned IDX_W = $clog2(NUM_EVT + 1);

    wr_strb_t           strb;
    rd_sel_t            rsel;
    logic [NUM_EVT-1:0] raw_q, enable_q, masked, grant, idx_clr;
    logic [IDX_W-1:0]   index;

    irq_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i  (addr_i),
        .wr_en_i (wr_en_i),
        .rd_en_i (rd_en_i),
        .strb_o  (strb),
        .rsel_o  (rsel)
    );

    irq_flag_bank #(.NUM_EVT(NUM_EVT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .strb_i    (strb),
        .wdata_i   (wr_data_i[NUM_EVT-1:0]),
        .hw_evt_i  (evt_i),
        .idx_clr_i (idx_clr),
        .raw_o     (raw_q),
        .enable_o  (enable_q)
    );

    assign masked  = raw_q & enable_q;
    assign irq_o   = |masked;

    irq_prio_enc #(.NUM_EVT(NUM_EVT)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_i  (masked),
        .grant_o (grant),
        .index_o (index)
    );

    assign idx_clr = strb.index_rd ? grant : '0;

    always_comb begin
        rd_data_o = '0;
        if (rsel.enable) rd_data_o = DATA_W'(enable_q);
        if (rsel.raw)    rd_data_o = DATA_W'(raw_q);
        if (rsel.masked) rd_data_o = DATA_W'(masked);
        if (rsel.index)  rd_data_o = DATA_W'(index);
    end

    generate
        if (DATA_W > NUM_EVT) begin : g_hi
            logic unused_wdata_hi;
            assign unused_wdata_hi = ^wr_data_i[DATA_W-1:NUM_EVT];
        end
    endgenerate

    // R7: write-only registers read back as zero
    a_r7_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && (addr_i == ADDR_W'(RA_SET) || addr_i == ADDR_W'(RA_CLEAR)))
        |-> (rd_data_o == '0));

    // R3: interrupt line follows the masked status read path
    a_r3_irq_vs_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == ADDR_W'(RA_MASKED)) |-> (irq_o == (rd_data_o != '0)));

endmodule

// File: tb/sim_irq_event_regs.sv
module sim_irq_event_regs;
    localparam int CLK_PERIOD = 10;
    localparam int NE = 4;
    localparam logic [3:0] A_EN = 0, A_RAW = 1, A_MSK = 2, A_SET = 3, A_CLR = 4, A_IDX = 5;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic [NE-1:0] evt = '0;
    logic        irq;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_event_regs #(.NUM_EVT(NE), .ADDR_W(4), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata),
        .rd_en_i(rd_en), .rd_data_o(rdata), .evt_i(evt), .irq_o(irq));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    function automatic int exp_idx(input int v);
        for (int i = 0; i < NE; i++) if (v[i]) return i + 1;
        return 0;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_rd(A_RAW, d); check("R1 raw", d, 0);
        bus_rd(A_EN, d);  check("R1 enable", d, 0);
        bus_rd(A_IDX, d); check("R1 index", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2 enable read/write, upper bits zero
        bus_wr(A_EN, 32'hFFFF_FFFF); bus_rd(A_EN, d); check("R2 enable all", d, 32'hF);
        bus_wr(A_EN, 32'h0);         bus_rd(A_EN, d); check("R2 enable none", d, 0);

        // R4 hardware pulse
        @(negedge clk); evt = 4'b0100;
        @(negedge clk); evt = '0;
        bus_rd(A_RAW, d); check("R4 hw pulse", d, 32'h4);
        check("R3 irq low when disabled", {31'b0, irq}, 0);

        // R5 set write, zero write no effect
        bus_wr(A_SET, 32'h0); bus_rd(A_RAW, d); check("R5 set zero no effect", d, 32'h4);
        bus_wr(A_SET, 32'h9); bus_rd(A_RAW, d); check("R5 set bits", d, 32'hD);

        // R7 write-only reads zero, writes to read-only addresses ignored
        bus_rd(A_SET, d); check("R7 set reads 0", d, 0);
        bus_rd(A_CLR, d); check("R7 clear reads 0", d, 0);
        bus_wr(A_RAW, 32'h0); bus_wr(A_MSK, 32'h0); bus_wr(A_IDX, 32'h0);
        bus_rd(A_RAW, d); check("R7 ro writes ignored raw", d, 32'hD);
        bus_rd(A_EN, d);  check("R7 ro writes ignored enable", d, 0);

        // R9 index read with nothing enabled: returns 0, clears nothing
        bus_rd(A_IDX, d); check("R9 idle index", d, 0);
        bus_rd(A_RAW, d); check("R9 idle no clear", d, 32'hD);

        // R6 clear while disabled, zero write no effect
        bus_wr(A_CLR, 32'h0); bus_rd(A_RAW, d); check("R6 clear zero no effect", d, 32'hD);
        bus_wr(A_CLR, 32'h5); bus_rd(A_RAW, d); check("R6 clear masked-off", d, 32'h8);

        // R10 hw pulse vs clear write on same bit
        bus_wr(A_CLR, 32'hF);
        @(negedge clk); evt = 4'b0010; addr = A_CLR; wdata = 32'h2; wr_en = 1'b1;
        @(negedge clk); evt = '0; wr_en = 1'b0;
        bus_rd(A_RAW, d); check("R10 set beats clear write", d, 32'h2);

        // R10 hw pulse vs index read retiring same bit
        bus_wr(A_EN, 32'hF);
        @(negedge clk); evt = 4'b0010; addr = A_IDX; rd_en = 1'b1;
        #1 check("R10 index value", rdata, 2);
        @(negedge clk); evt = '0; rd_en = 1'b0;
        bus_rd(A_RAW, d); check("R10 set beats index clear", d, 32'h2);

        // R3 R8 R9 sweep over every raw x enable pair
        for (int m = 0; m < 16; m++) begin
            for (int r = 0; r < 16; r++) begin
                int mk, ix;
                mk = r & m;
                ix = exp_idx(mk);
                bus_wr(A_CLR, 32'hF);
                bus_wr(A_SET, r);
                bus_wr(A_EN, m);
                bus_rd(A_RAW, d); check("R5 sweep raw", d, r);
                bus_rd(A_MSK, d); check("R3 sweep masked", d, mk);
                check("R3 sweep irq", {31'b0, irq}, {31'b0, (mk != 0)});
                bus_rd(A_IDX, d); check("R8 sweep index", d, ix);
                bus_rd(A_RAW, d);
                check("R9 sweep retire", d, (ix == 0) ? r : (r & ~(1 << (ix - 1))));
            end
        end

        finished = 1;
        summary();
        $finish;
    end
endmodule